// File: doc/BRIEF.md
# Dynamic bus size converter

The converter accepts one 32-bit transfer request from inside the chip: a word address, four active-high byte enables, a direction and, for writes, the data. It runs that request on an external data bus whose width is 32, 16 or 8 bits. The width is not fixed. Two active-low size inputs are registered on every clock, and the value held from the clock before each ready decides how many of the still-pending bytes that ready moves. The external side always sees the full set of bytes that remain. After each ready the bytes just moved leave the pending set, and the request ends once the set is empty.

Write data is placed so that any width finds its bytes on the lanes it uses. Lanes D7:D0 carry the lowest pending byte. Lanes D15:D8 carry the odd byte of the lowest pending halfword. Lanes D31:D16 carry bytes 2 and 3 unchanged. Read data is taken from the lanes the chosen width uses and assembled into a 32-bit result that is returned together with a one-cycle done pulse.

Top module: `bus_size_conv`

## Requirements
- R1: During and right after reset, busy and done are 0 and bus_be_n is 4'hF.
- R2: With busy at 0, a cycle with req_valid at 1 and a nonzero req_be starts a transfer: at the next edge busy rises and the pending mask becomes req_be. A request with req_be of 4'h0 is ignored.
- R3: While busy, bus_be_n is the inverse of the pending mask, bus_lo is the index of the lowest pending byte, and bus_word and bus_we hold the captured request. While idle, bus_be_n is 4'hF.
- R4: sz8_n and sz16_n are registered on every clock. The registered value at a ready edge picks the width: sz8_n low gives 8 bits, even when sz16_n is also low; sz16_n low alone gives 16 bits; both high give 32 bits.
- R5: At 32-bit width, a ready (rdy_n low while busy) clears the whole pending mask.
- R6: At 16-bit width, a ready clears the pending bytes of the halfword (bytes 0-1 or 2-3) that holds the lowest pending byte.
- R7: At 8-bit width, a ready clears only the lowest pending byte.
- R8: While busy with a write, bus_wdata[7:0] is the lowest pending byte, bus_wdata[15:8] is byte (bus_lo with bit 0 forced to 1), and bus_wdata[31:16] is bytes 3:2 of the write data.
- R9: On each ready, every byte i that is cleared is stored into rd_data byte i. It is taken from lane i at 32 bits, from lane i mod 2 at 16 bits, and from lane 0 at 8 bits. Bytes that were never enabled read as 0.
- R10: The ready that empties the mask drops busy at that edge and raises done for exactly one cycle. A request with a single enabled byte ends on its first ready at any width.
- R11: rdy_n has no effect while idle.
- R12: req_valid has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | AW | Word address of the request |
| req_be | input | 4 | Active-high byte enables |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Assembled read data |
| bus_word | output | AW | External word address |
| bus_lo | output | 2 | Index of the lowest pending byte |
| bus_be_n | output | 4 | Active-low byte enables of the pending bytes |
| bus_we | output | 1 | External direction |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | External read data |
| rdy_n | input | 1 | Active-low ready |
| sz16_n | input | 1 | Active-low 16-bit size request |
| sz8_n | input | 1 | Active-low 8-bit size request |

## Verification
Full-word reads and writes run at each fixed width. At 32 bits they end on one ready, at 16 bits on two and at 8 bits on four. This separates the three clearing rules and checks the lane that each assembled byte comes from. Sparse masks (4'b0110, 4'b1010 and single bytes) show whether gaps are skipped rather than spent as empty cycles, and whether the halfword rule stays within one halfword. A run with both size inputs low tests the 8-bit priority. A run where the size changes on every clock, with wait states in between, shows whether the width is taken from the previous clock rather than the current one. Ready pulses while idle and requests held high while busy must leave the state unchanged.

// File: rtl/bus_size_conv.sv
module bus_size_conv #(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_word,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rd_data,
  output logic [AW-1:0] bus_word,
  output logic [1:0]    bus_lo,
  output logic [3:0]    bus_be_n,
  output logic          bus_we,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          rdy_n,
  input  logic          sz16_n,
  input  logic          sz8_n
);

  logic          busy_q, done_q, we_q;
  logic [3:0]    pend_q;
  logic [AW-1:0] word_q;
  logic [31:0]   wd_q, rd_q;
  logic          s8_q, s16_q;

  logic [1:0] lo;
  logic [3:0] half_m, take;
  logic       w8, w16, fire;

  assign lo = pend_q[0] ? 2'd0 : pend_q[1] ? 2'd1 : pend_q[2] ? 2'd2 : 2'd3;
  assign half_m = lo[1] ? 4'b1100 : 4'b0011;
  assign w8  = ~s8_q;
  assign w16 = ~s16_q & s8_q;
  assign take = w8 ? (4'b0001 << lo) : w16 ? (pend_q & half_m) : pend_q;
  assign fire = busy_q & ~rdy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s8_q  <= 1'b1;
      s16_q <= 1'b1;
    end else begin
      s8_q  <= sz8_n;
      s16_q <= sz16_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      we_q   <= 1'b0;
      pend_q <= 4'h0;
      word_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        pend_q <= pend_q & ~take;
        for (int i = 0; i < 4; i++) begin
          if (take[i]) begin
            if (w8)       rd_q[8*i +: 8] <= bus_rdata[7:0];
            else if (w16) rd_q[8*i +: 8] <= bus_rdata[8*(i%2) +: 8];
            else          rd_q[8*i +: 8] <= bus_rdata[8*i +: 8];
          end
        end
        if ((pend_q & ~take) == 4'h0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (!busy_q && req_valid && req_be != 4'h0) begin
        busy_q <= 1'b1;
        pend_q <= req_be;
        we_q   <= req_write;
        word_q <= req_word;
        wd_q   <= req_wdata;
        rd_q   <= '0;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign rd_data   = rd_q;
  assign bus_word  = word_q;
  assign bus_we    = we_q;
  assign bus_lo    = busy_q ? lo : 2'd0;
  assign bus_be_n  = busy_q ? ~pend_q : 4'hF;
  assign bus_wdata = {wd_q[31:16], wd_q[{lo[1], 1'b1, 3'b000} +: 8], wd_q[{lo, 3'b000} +: 8]};

endmodule

module bus_size_conv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       rdy_n,
  input logic       sz16_n,
  input logic       sz8_n,
  input logic       req_valid,
  input logic [3:0] req_be,
  input logic [3:0] bus_be_n
);
  logic p8, p16;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p8  <= 1'b0;
      p16 <= 1'b0;
    end else begin
      p8  <= ~sz8_n;
      p16 <= ~sz16_n;
    end
  end

  assert_idle_be_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_be_n == 4'hF);
  assert_wait_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rdy_n) |=> $stable(bus_be_n));
  assert_full_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdy_n && !p8 && !p16) |=> (!busy && done));
  assert_byte_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdy_n && p8) |=> ($countones(~bus_be_n) + 1 == $countones(~$past(bus_be_n))));
  assert_half_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdy_n && p16 && !p8 && bus_be_n == 4'h0) |=> (bus_be_n == 4'b0011));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !done);
  assert_empty_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && (!req_valid || req_be == 4'h0)) |=> !busy);
endmodule

bind bus_size_conv bus_size_conv_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rdy_n(rdy_n),
  .sz16_n(sz16_n), .sz8_n(sz8_n), .req_valid(req_valid), .req_be(req_be),
  .bus_be_n(bus_be_n)
);

// File: tb/bus_size_conv_tb.sv
module bus_size_conv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_word = '0;
  logic [3:0] req_be = 4'h0;
  logic [31:0] req_wdata = '0, bus_rdata = '0;
  logic rdy_n = 1, sz16_n = 1, sz8_n = 1;
  logic busy, done, bus_we;
  logic [31:0] rd_data, bus_wdata;
  logic [AW-1:0] bus_word;
  logic [1:0] bus_lo;
  logic [3:0] bus_be_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_size_conv #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_be(req_be), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .bus_word(bus_word),
    .bus_lo(bus_lo), .bus_be_n(bus_be_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rdy_n(rdy_n), .sz16_n(sz16_n), .sz8_n(sz8_n));

  int n_checks = 0, n_errs = 0, cyc = 0;
  string phase = "R2";
  string step_tag = "R3";

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  bit m_busy = 0, m_done = 0, m_we = 0;
  logic [3:0] m_pend = 0;
  logic [AW-1:0] m_word = 0;
  logic [31:0] m_wd = 0, m_rd = 0;
  int m_w = 32;

  function automatic int width_of(logic s16, logic s8);
    if (!s8) return 8;
    if (!s16) return 16;
    return 32;
  endfunction

  function automatic int lowest(logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pend = 0; m_w = 32; m_rd = 0;
    end else begin
      int w_now;
      w_now = width_of(sz16_n, sz8_n);
      m_done = 0;
      if (m_busy && !rdy_n) begin
        int l;
        l = lowest(m_pend);
        step_tag = (m_w == 32) ? "R5" : (m_w == 16) ? "R6" : "R7";
        for (int i = 0; i < 4; i++) begin
          bit tk;
          int lane;
          tk = (m_w == 32) ? m_pend[i] : (m_w == 16) ? (m_pend[i] && (i/2 == l/2)) : (i == l);
          lane = (m_w == 32) ? i : (m_w == 16) ? i % 2 : 0;
          if (tk) begin
            m_rd[8*i +: 8] = bus_rdata[8*lane +: 8];
            m_pend[i] = 1'b0;
          end
        end
        if (m_pend == 0) begin m_busy = 0; m_done = 1; end
      end else if (!m_busy && req_valid && req_be != 0) begin
        m_busy = 1; m_pend = req_be; m_we = req_write; m_word = req_word; m_wd = req_wdata; m_rd = 0;
        step_tag = "R3";
      end
      m_w = w_now;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, phase, 32'(busy), 32'(m_busy));
      chk(done == m_done, "R10", 32'(done), 32'(m_done));
      chk(bus_be_n == (m_busy ? ~m_pend : 4'hF), step_tag, 32'(bus_be_n), 32'(m_busy ? ~m_pend : 4'hF));
      if (m_busy) begin
        int l;
        l = lowest(m_pend);
        chk(bus_lo == 2'(l), "R3", 32'(bus_lo), 32'(l));
        chk(bus_word == m_word && bus_we == m_we, "R3", 32'(bus_word), 32'(m_word));
        if (m_we) begin
          logic [31:0] ew;
          ew = {m_wd[31:16], m_wd[8*(l|1) +: 8], m_wd[8*l +: 8]};
          chk(bus_wdata == ew, "R8", bus_wdata, ew);
        end
      end
      if (m_done) chk(rd_data == m_rd, "R9", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic set_size(int mode, int k);
    int md;
    md = (mode == 4) ? (k % 3) : mode;
    case (md)
      0: begin sz16_n = 1; sz8_n = 1; end
      1: begin sz16_n = 0; sz8_n = 1; end
      2: begin sz16_n = 1; sz8_n = 0; end
      default: begin sz16_n = 0; sz8_n = 0; end
    endcase
  endtask

  task automatic xfer(logic [3:0] be, bit we, logic [AW-1:0] wd_addr, logic [31:0] wd,
                      int mode, bit hold_req);
    int k;
    set_size(mode, 0);
    @(negedge clk);
    req_valid = 1; req_be = be; req_write = we; req_word = wd_addr; req_wdata = wd;
    @(negedge clk);
    if (hold_req) begin
      // R12: a different request stays asserted while busy
      req_be = 4'hF; req_word = ~wd_addr; req_wdata = ~wd; req_write = ~we;
    end else req_valid = 0;
    k = 0;
    while (m_busy && k < 200) begin
      set_size(mode, k + 1);
      rdy_n = (k % 3 == 1);
      bus_rdata = 32'h1F2E3D4C ^ (32'(k) * 32'h01030507);
      @(negedge clk);
      k++;
    end
    req_valid = 0; rdy_n = 1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && bus_be_n == 4'hF, "R1", {busy, done, bus_be_n}, 32'h0F);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && bus_be_n == 4'hF, "R1", {busy, done, bus_be_n}, 32'h0F);

    xfer(4'hF, 0, 30'h0001234, 32'h0, 0, 0);          // R5 32-bit read
    xfer(4'hF, 1, 30'h0004321, 32'hA1B2C3D4, 0, 0);   // R5 32-bit write
    xfer(4'hF, 0, 30'h0000100, 32'h0, 1, 0);          // R6 16-bit read
    xfer(4'hF, 0, 30'h0000200, 32'h0, 2, 0);          // R7 8-bit read
    xfer(4'hF, 1, 30'h0000300, 32'h55667788, 3, 0);   // R4 both low selects 8 bits
    xfer(4'b1010, 1, 30'h0000400, 32'hCAFEF00D, 2, 0);// R8 sparse write
    xfer(4'b0110, 0, 30'h0000500, 32'h0, 1, 0);       // R6 straddling halfwords
    xfer(4'b1001, 1, 30'h0000600, 32'h12345678, 1, 0);
    phase = "R10";
    xfer(4'b0100, 0, 30'h0000700, 32'h0, 2, 0);       // R10 single byte at 8 bits
    xfer(4'b1000, 1, 30'h0000701, 32'h9ABCDEF0, 1, 0);
    xfer(4'b0010, 0, 30'h0000702, 32'h0, 0, 0);
    phase = "R4";
    xfer(4'hF, 1, 30'h0000800, 32'h0BADBEEF, 4, 0);   // R4 size changes every clock
    xfer(4'hF, 0, 30'h0000801, 32'h0, 4, 0);
    phase = "R12";
    xfer(4'b0011, 0, 30'h0000900, 32'h0, 2, 1);       // R12 request held while busy
    phase = "R2";
    @(negedge clk); req_valid = 1; req_be = 4'h0;     // R2 empty mask ignored
    repeat (3) @(negedge clk);
    req_valid = 0;
    phase = "R11";
    rdy_n = 0;                                        // R11 ready while idle
    repeat (4) @(negedge clk);
    rdy_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R11", {busy, done}, 32'h0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule